// File: doc/BRIEF.md
# CAN Channel Bus-Off Recovery Controller

This block keeps the operating mode of one CAN channel (reset, halt or communication) and decides what happens when the channel goes bus-off. Software can pick one of four recovery policies. The first is standard automatic recovery, where the channel stays in communication. The second forces halt at bus-off entry and the third forces halt when bus-off ends. The fourth halts only when software asks for it while the channel is bus-off. Once a policy has forced halt, the channel stays there until software asks for communication again.

The block also holds a 16-bit control word. It contains the communication test mode selection and its enable, an error display selection, the recovery policy and a transmit-abort interrupt enable. Each field can be written only in the modes listed below. Bus-off entry and end events arrive as single-cycle pulses from the error counting logic, which sits outside this block.

The external reset is asynchronous, and its release is synchronized inside the block. Internal reset therefore ends on the second rising clock edge after `rst_n` goes high. Every output is registered, so any stimulus sampled at clock edge k shows at the outputs just after edge k.

Top module: `can_busoff_ctrl`

## Requirements
- R1: While reset is active, and until the first stimulus after it, `chan_mode` is 2'b01 (reset mode), `busoff` is 0 and `cfg_rdata` is 16'h0000.
- R2: A mode request with `mode_req` 2'b00 selects communication, 2'b01 selects reset and 2'b10 selects halt. Code 2'b11 is ignored. A reset request wins over every other cause of mode change. Communication and halt requests lose to a forced halt in the same cycle.
- R3: With recovery policy 2'b00, bus-off entry and end events leave the channel in communication mode.
- R4: With policy 2'b01, a bus-off entry pulse in communication mode moves the channel to halt mode (2'b10) on the next cycle.
- R5: With policy 2'b10, a bus-off end pulse while `busoff` is 1 in communication mode moves the channel to halt mode.
- R6: With policy 2'b11, `prog_halt_req` in communication mode moves the channel to halt mode only while `busoff` is 1. The request has no effect when the channel is not bus-off, and no effect under any other policy.
- R7: Halt mode is left only through a software request. Bus-off events and `prog_halt_req` do not change the mode while the channel is halted.
- R8: The test enable (bit 8) and test select (bits 10:9) fields change on a write only in halt mode, and both are cleared while in reset mode. `test_active` shows the enable. `test_mode` shows the select when enabled and 2'b00 otherwise (00 standard, 01 listen-only, 10 external loopback, 11 internal loopback).
- R9: The recovery policy (bits 6:5) and error display (bit 7) fields change on a write only in reset or halt mode. `err_disp_all` shows bit 7.
- R10: The transmit-abort interrupt enable (bit 0) takes a write in any mode and drives `tx_abort_ie`. Bits 15:11 and 4:1 always read 0.
- R11: `busoff` is set by `bo_enter`, cleared by `bo_end` (entry wins if both pulse together) and held at 0 in reset mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_req_vld | input | 1 | Software mode request strobe |
| mode_req | input | 2 | Requested mode: 00 comm, 01 reset, 10 halt |
| bo_enter | input | 1 | Bus-off entry pulse |
| bo_end | input | 1 | Bus-off end pulse |
| prog_halt_req | input | 1 | Software halt request used by policy 11 |
| cfg_wr | input | 1 | Control word write strobe |
| cfg_wdata | input | 16 | Control word write data |
| chan_mode | output | 2 | Current mode: 00 comm, 01 reset, 10 halt |
| busoff | output | 1 | Channel is bus-off |
| halt_ind | output | 1 | Channel is in halt mode |
| test_active | output | 1 | Communication test mode enabled |
| test_mode | output | 2 | Active test mode selection |
| tx_abort_ie | output | 1 | Transmit-abort interrupt enable |
| err_disp_all | output | 1 | Error display selection |
| cfg_rdata | output | 16 | Control word read-back |

## Verification
The assertions assume that every input is at a known level on each clock edge. They assume nothing about how often bus-off events occur: entry and end pulses may come together, and an end pulse may come while the channel is not bus-off. The properties that check forced halts also include "no reset request in the same cycle" in their trigger, so that they do not depend on the request priority. The random stimulus draws each strobe on its own with a low probability and draws full 16-bit write words. This covers simultaneous events, the unused request code 11 and writes to the reserved bits.

// File: rtl/can_boc_pkg.sv
package can_boc_pkg;

  typedef enum logic [1:0] {
    CM_COMM  = 2'b00,
    CM_RESET = 2'b01,
    CM_HALT  = 2'b10
  } chan_mode_e;

  typedef enum logic [1:0] {
    RP_AUTO     = 2'b00,
    RP_ON_ENTRY = 2'b01,
    RP_ON_END   = 2'b10,
    RP_ON_PROG  = 2'b11
  } recov_pol_e;

  localparam int unsigned BIT_TAIE    = 0;
  localparam int unsigned BIT_POL_LO  = 5;
  localparam int unsigned BIT_ERRD    = 7;
  localparam int unsigned BIT_TEN     = 8;
  localparam int unsigned BIT_TSEL_LO = 9;
  localparam int unsigned POL_W       = 2;
  localparam int unsigned TSEL_W      = 2;

  typedef struct packed {
    logic [TSEL_W-1:0] tsel;
    logic              ten;
    logic              errd;
    recov_pol_e        pol;
    logic              taie;
  } ctrl_fields_t;

endpackage

// File: rtl/boc_rst_sync.sv
module boc_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_n;

  always_comb begin
    sync_n = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_n;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/boc_ctrl_reg.sv
module boc_ctrl_reg
  import can_boc_pkg::*;
#(
  parameter int unsigned REG_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  chan_mode_e         mode_q,
  input  logic               wr_en,
  input  logic [REG_W-1:0]   wdata,
  output ctrl_fields_t       fields,
  output logic [REG_W-1:0]   rdata
);
  ctrl_fields_t f_q;
  ctrl_fields_t f_n;
  logic         cfg_open;
  logic         upd_en;

  assign cfg_open = (mode_q == CM_RESET) || (mode_q == CM_HALT);
  assign upd_en   = wr_en || (mode_q == CM_RESET);

  always_comb begin
    f_n = f_q;
    if (wr_en) begin
      f_n.taie = wdata[BIT_TAIE];
      if (cfg_open) begin
        f_n.errd = wdata[BIT_ERRD];
        f_n.pol  = recov_pol_e'(wdata[BIT_POL_LO +: POL_W]);
      end
      if (mode_q == CM_HALT) begin
        f_n.ten  = wdata[BIT_TEN];
        f_n.tsel = wdata[BIT_TSEL_LO +: TSEL_W];
      end
    end
    if (mode_q == CM_RESET) begin
      f_n.ten  = 1'b0;
      f_n.tsel = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      f_q <= '0;
    else if (upd_en) f_q <= f_n;
  end

  always_comb begin
    rdata                          = '0;
    rdata[BIT_TAIE]                = f_q.taie;
    rdata[BIT_POL_LO +: POL_W]     = f_q.pol;
    rdata[BIT_ERRD]                = f_q.errd;
    rdata[BIT_TEN]                 = f_q.ten;
    rdata[BIT_TSEL_LO +: TSEL_W]   = f_q.tsel;
  end

  assign fields = f_q;

  a_r8_test_cleared_in_reset : assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == CM_RESET) |=> (f_q.ten == 1'b0 && f_q.tsel == '0));

  a_r8_test_locked_in_comm : assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == CM_COMM) |=> ($stable(f_q.ten) && $stable(f_q.tsel)));

  a_r9_policy_locked_in_comm : assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == CM_COMM) |=> ($stable(f_q.pol) && $stable(f_q.errd)));

  a_r10_taie_takes_write : assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (f_q.taie == $past(wdata[BIT_TAIE])));
endmodule

// File: rtl/boc_busoff_track.sv
module boc_busoff_track
  import can_boc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  chan_mode_e mode_q,
  input  recov_pol_e pol,
  input  logic       bo_enter,
  input  logic       bo_end,
  input  logic       prog_halt_req,
  output logic       busoff_q,
  output logic       force_halt
);
  logic busoff_n;
  logic bo_upd;

  assign bo_upd = bo_enter || bo_end || (mode_q == CM_RESET);

  always_comb begin
    if (mode_q == CM_RESET) busoff_n = 1'b0;
    else if (bo_enter)      busoff_n = 1'b1;
    else                    busoff_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      busoff_q <= 1'b0;
    else if (bo_upd) busoff_q <= busoff_n;
  end

  always_comb begin
    force_halt = 1'b0;
    if (mode_q == CM_COMM) begin
      unique case (pol)
        RP_AUTO:     force_halt = 1'b0;
        RP_ON_ENTRY: force_halt = bo_enter;
        RP_ON_END:   force_halt = bo_end && busoff_q;
        RP_ON_PROG:  force_halt = prog_halt_req && busoff_q;
        default:     force_halt = 1'b0;
      endcase
    end
  end

  a_r11_entry_sets : assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q != CM_RESET && bo_enter) |=> busoff_q);

  a_r11_end_clears : assert property (@(posedge clk) disable iff (!rst_n)
    (bo_end && !bo_enter) |=> !busoff_q);

  a_r11_cleared_in_reset : assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == CM_RESET) |=> !busoff_q);
endmodule

// File: rtl/boc_mode_fsm.sv
module boc_mode_fsm
  import can_boc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_vld,
  input  logic [1:0] req,
  input  logic       force_halt,
  output chan_mode_e mode_q
);
  chan_mode_e mode_n;
  chan_mode_e req_mode;
  logic       req_reset;
  logic       req_move;

  assign req_mode  = chan_mode_e'(req);
  assign req_reset = req_vld && (req_mode == CM_RESET);
  assign req_move  = req_vld && ((req_mode == CM_COMM) || (req_mode == CM_HALT));

  always_comb begin
    mode_n = mode_q;
    if (req_reset)       mode_n = CM_RESET;
    else if (force_halt) mode_n = CM_HALT;
    else if (req_move)   mode_n = req_mode;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= CM_RESET;
    else        mode_q <= mode_n;
  end

  a_r2_reset_request_wins : assert property (@(posedge clk) disable iff (!rst_n)
    req_reset |=> (mode_q == CM_RESET));

  a_r2_code3_ignored : assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && req == 2'b11 && !force_halt) |=> $stable(mode_q));
endmodule

// File: rtl/can_busoff_ctrl.sv
module can_busoff_ctrl
  import can_boc_pkg::*;
#(
  parameter int unsigned REG_W     = 16,
  parameter int unsigned RST_STAGE = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_req_vld,
  input  logic [1:0]       mode_req,
  input  logic             bo_enter,
  input  logic             bo_end,
  input  logic             prog_halt_req,
  input  logic             cfg_wr,
  input  logic [REG_W-1:0] cfg_wdata,
  output logic [1:0]       chan_mode,
  output logic             busoff,
  output logic             halt_ind,
  output logic             test_active,
  output logic [1:0]       test_mode,
  output logic             tx_abort_ie,
  output logic             err_disp_all,
  output logic [REG_W-1:0] cfg_rdata
);
  logic         rst_i_n;
  chan_mode_e   mode_q;
  ctrl_fields_t fields;
  logic         busoff_q;
  logic         force_halt;

  boc_rst_sync #(.STAGES(RST_STAGE)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_i_n)
  );

  boc_ctrl_reg #(.REG_W(REG_W)) u_reg (
    .clk(clk), .rst_n(rst_i_n), .mode_q(mode_q), .wr_en(cfg_wr),
    .wdata(cfg_wdata), .fields(fields), .rdata(cfg_rdata)
  );

  boc_busoff_track u_bo (
    .clk(clk), .rst_n(rst_i_n), .mode_q(mode_q), .pol(fields.pol),
    .bo_enter(bo_enter), .bo_end(bo_end), .prog_halt_req(prog_halt_req),
    .busoff_q(busoff_q), .force_halt(force_halt)
  );

  boc_mode_fsm u_fsm (
    .clk(clk), .rst_n(rst_i_n), .req_vld(mode_req_vld), .req(mode_req),
    .force_halt(force_halt), .mode_q(mode_q)
  );

  assign chan_mode    = mode_q;
  assign busoff       = busoff_q;
  assign halt_ind     = (mode_q == CM_HALT);
  assign test_active  = fields.ten;
  assign test_mode    = fields.ten ? fields.tsel : 2'b00;
  assign tx_abort_ie  = fields.taie;
  assign err_disp_all = fields.errd;

  logic no_rst_req;
  assign no_rst_req = !(mode_req_vld && mode_req == 2'b01);

  a_r3_auto_stays_comm : assert property (@(posedge clk) disable iff (!rst_i_n)
    (fields.pol == RP_AUTO && chan_mode == 2'b00 && !mode_req_vld) |=> (chan_mode == 2'b00));

  a_r4_halt_on_entry : assert property (@(posedge clk) disable iff (!rst_i_n)
    (fields.pol == RP_ON_ENTRY && chan_mode == 2'b00 && bo_enter && no_rst_req)
      |=> (chan_mode == 2'b10));

  a_r5_halt_on_end : assert property (@(posedge clk) disable iff (!rst_i_n)
    (fields.pol == RP_ON_END && chan_mode == 2'b00 && busoff && bo_end && no_rst_req)
      |=> (chan_mode == 2'b10));

  a_r6_prog_halt_when_busoff : assert property (@(posedge clk) disable iff (!rst_i_n)
    (fields.pol == RP_ON_PROG && chan_mode == 2'b00 && busoff && prog_halt_req && no_rst_req)
      |=> (chan_mode == 2'b10));

  a_r6_prog_ignored_not_busoff : assert property (@(posedge clk) disable iff (!rst_i_n)
    (chan_mode == 2'b00 && !busoff && !bo_enter && !mode_req_vld) |=> (chan_mode == 2'b00));

  a_r7_halt_holds : assert property (@(posedge clk) disable iff (!rst_i_n)
    (halt_ind && !mode_req_vld) |=> halt_ind);

  a_r10_reserved_zero : assert property (@(posedge clk) disable iff (!rst_i_n)
    (cfg_rdata[15:11] == 5'd0 && cfg_rdata[4:1] == 4'd0));
endmodule

// File: tb/test_can_busoff_ctrl.sv
module test_can_busoff_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        mode_req_vld, bo_enter, bo_end, prog_halt_req, cfg_wr;
  logic [1:0]  mode_req;
  logic [15:0] cfg_wdata;
  logic [1:0]  chan_mode, test_mode;
  logic        busoff, halt_ind, test_active, tx_abort_ie, err_disp_all;
  logic [15:0] cfg_rdata;

  int unsigned n_vec  = 0;
  int unsigned n_fail = 0;

  // reference state
  logic [1:0] m_mode;
  logic       m_bo, m_taie, m_errd, m_ten;
  logic [1:0] m_pol, m_tsel;
  string      m_tag;

  always #2 clk = ~clk;

  can_busoff_ctrl i_can_busoff_ctrl (
    .clk(clk), .rst_n(rst_n), .mode_req_vld(mode_req_vld), .mode_req(mode_req),
    .bo_enter(bo_enter), .bo_end(bo_end), .prog_halt_req(prog_halt_req),
    .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .chan_mode(chan_mode), .busoff(busoff),
    .halt_ind(halt_ind), .test_active(test_active), .test_mode(test_mode),
    .tx_abort_ie(tx_abort_ie), .err_disp_all(err_disp_all), .cfg_rdata(cfg_rdata)
  );

  function automatic logic [15:0] exp_rdata();
    return {5'd0, m_tsel, m_ten, m_errd, m_pol, 4'd0, m_taie};
  endfunction

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic check_all();
    chk(m_tag, {14'd0, chan_mode}, {14'd0, m_mode});
    chk("R7 halt_ind", {15'd0, halt_ind}, {15'd0, m_mode == 2'b10});
    chk("R11 busoff", {15'd0, busoff}, {15'd0, m_bo});
    chk("R8 test fields", {5'd0, cfg_rdata[10:8], 8'd0}, {5'd0, m_tsel, m_ten, 8'd0});
    chk("R8 test outputs", {13'd0, test_active, test_mode},
        {13'd0, m_ten, (m_ten ? m_tsel : 2'b00)});
    chk("R9 policy errd", {8'd0, cfg_rdata[7:5], err_disp_all, 4'd0},
        {8'd0, m_errd, m_pol, m_errd, 4'd0});
    chk("R10 taie reserved", {cfg_rdata[15:11], cfg_rdata[4:0], tx_abort_ie, 5'd0},
        {5'd0, 4'd0, m_taie, m_taie, 5'd0});
  endtask

  task automatic step(input logic vld, input logic [1:0] req, input logic ent,
                      input logic en, input logic prog, input logic wr,
                      input logic [15:0] wd);
    logic       force_h;
    logic [1:0] n_mode;
    @(negedge clk);
    mode_req_vld = vld; mode_req = req; bo_enter = ent; bo_end = en;
    prog_halt_req = prog; cfg_wr = wr; cfg_wdata = wd;
    @(posedge clk);
    force_h = (m_mode == 2'b00) && ((m_pol == 2'b01 && ent) ||
              (m_pol == 2'b10 && en && m_bo) || (m_pol == 2'b11 && prog && m_bo));
    n_mode = m_mode;
    if (vld && req == 2'b01) begin n_mode = 2'b01; m_tag = "R2 reset request"; end
    else if (force_h) begin
      n_mode = 2'b10;
      m_tag = (m_pol == 2'b01) ? "R4 mode" : (m_pol == 2'b10) ? "R5 mode" : "R6 mode";
    end else if (vld && req != 2'b11) begin n_mode = req; m_tag = "R2 mode request"; end
    else m_tag = (m_mode == 2'b10) ? "R7 mode" : (m_pol == 2'b00) ? "R3 mode" : "R6 mode";
    if (wr) begin
      m_taie = wd[0];
      if (m_mode != 2'b00) begin m_pol = wd[6:5]; m_errd = wd[7]; end
      if (m_mode == 2'b10) begin m_ten = wd[8]; m_tsel = wd[10:9]; end
    end
    if (m_mode == 2'b01) begin m_ten = 1'b0; m_tsel = 2'b00; end
    if (m_mode == 2'b01) m_bo = 1'b0;
    else if (ent)        m_bo = 1'b1;
    else if (en)         m_bo = 1'b0;
    m_mode = n_mode;
    #1;
    check_all();
  endtask

  task automatic idle(); step(0, 2'b00, 0, 0, 0, 0, 16'h0); endtask
  task automatic req_mode(input logic [1:0] r); step(1, r, 0, 0, 0, 0, 16'h0); endtask
  task automatic wr(input logic [15:0] d); step(0, 2'b00, 0, 0, 0, 1, d); endtask

  task automatic set_policy(input logic [1:0] p);
    req_mode(2'b10);
    wr({9'd0, p, 5'd0});
    req_mode(2'b00);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd7031));
    rst_n = 1'b0;
    mode_req_vld = 0; mode_req = 0; bo_enter = 0; bo_end = 0;
    prog_halt_req = 0; cfg_wr = 0; cfg_wdata = '0;
    m_mode = 2'b01; m_bo = 0; m_taie = 0; m_errd = 0; m_ten = 0; m_pol = 0; m_tsel = 0;
    m_tag = "R1 reset mode";
    repeat (3) @(posedge clk);
    #1;
    check_all(); // R1 during reset
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check_all(); // R1 after release

    // R9 R8: reset mode accepts policy/errd, clears test fields
    wr(16'hFFFF);
    chk("R9 reset write", cfg_rdata, 16'h00E1);
    // R8: halt accepts test fields
    req_mode(2'b10);
    wr(16'hFFFF);
    chk("R8 halt write", cfg_rdata, 16'h07E1);
    chk("R8 internal loopback", {14'd0, test_mode}, 16'd3);
    // R10 R8 R9: communication mode only takes taie
    req_mode(2'b00);
    wr(16'h0000);
    chk("R10 comm write", cfg_rdata, 16'h07E0);
    // R2: code 11 ignored
    req_mode(2'b11);
    chk("R2 code 11", {14'd0, chan_mode}, 16'd0);

    // R4: halt at entry
    req_mode(2'b01);
    set_policy(2'b01);
    step(0, 2'b00, 1, 0, 0, 0, 16'h0);
    chk("R4 entry halt", {14'd0, chan_mode}, 16'd2);
    // R7: events in halt keep halt
    step(0, 2'b00, 0, 1, 1, 0, 16'h0);
    chk("R7 held", {14'd0, chan_mode}, 16'd2);
    req_mode(2'b00);

    // R5: halt at end
    set_policy(2'b10);
    step(0, 2'b00, 1, 0, 0, 0, 16'h0);
    chk("R5 still comm", {14'd0, chan_mode}, 16'd0);
    step(0, 2'b00, 0, 1, 0, 0, 16'h0);
    chk("R5 end halt", {14'd0, chan_mode}, 16'd2);
    req_mode(2'b00);

    // R6: program halt only while bus-off
    set_policy(2'b11);
    step(0, 2'b00, 0, 0, 1, 0, 16'h0);
    chk("R6 ignored not busoff", {14'd0, chan_mode}, 16'd0);
    step(0, 2'b00, 1, 0, 0, 0, 16'h0);
    step(0, 2'b00, 0, 0, 1, 0, 16'h0);
    chk("R6 prog halt", {14'd0, chan_mode}, 16'd2);
    req_mode(2'b00);

    // R3: auto recovery
    set_policy(2'b00);
    step(0, 2'b00, 1, 0, 1, 0, 16'h0);
    step(0, 2'b00, 0, 1, 0, 0, 16'h0);
    chk("R3 auto", {14'd0, chan_mode}, 16'd0);
    // R11: both pulses, entry wins
    step(0, 2'b00, 1, 1, 0, 0, 16'h0);
    chk("R11 both", {15'd0, busoff}, 16'd1);
    idle();

    // random phase
    for (int i = 0; i < 4000; i++) begin
      step(($urandom % 8) == 0, 2'($urandom), ($urandom % 12) == 0,
           ($urandom % 12) == 0, ($urandom % 6) == 0, ($urandom % 6) == 0,
           16'($urandom));
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end
endmodule